// File: doc/BRIEF.md
# Cassette Data Decoder with Load and Verify

This block turns the squared-up output of a cassette read comparator into bytes, finds the start of a recording and then either loads the recording into an external byte memory or checks it against that memory. Each bit is carried by the time between two level changes on the tape line. After the line has passed through a short synchronizer, an interval timer labels each gap as short (a one) or long (a zero). If no change comes for a long time, the timer treats that moment as a change. A byte framer skips ones until it sees a zero start bit. It then collects eight data bits, least significant first.

A sequencer discards bytes until it sees the two-byte marker 0x50 then 0x36. It then takes a fixed count of payload bytes, organised as pages, and keeps an 8-bit running sum of them. In load mode every payload byte is written to memory at its index. In verify mode every payload byte is compared with the memory word at that index. The byte after the payload must equal the running sum. On completion the block raises `done`. It raises `error` for a verify mismatch or a bad sum. Both flags hold until reset, and a new transfer starts after reset.

Top module: `tape_loader`

## Requirements
- R1: After reset `done`, `error` and `mem_wr_en` are low.
- R2: The tape input passes through two flip-flops before edge detection. A gap between transitions shorter than THRESH_TICKS*TICK_CYC clock cycles decodes as bit 1. A gap of that length or longer decodes as bit 0.
- R3: If no transition arrives for TIMEOUT_CYC cycles, that moment is taken as a transition that yields bit 0. The next gap is measured from it.
- R4: While no byte is in progress, 1 bits are skipped. A 0 bit starts a byte, and the next eight bits form it, least significant bit first. Bits after the eighth are not checked, so a new start bit may follow at once.
- R5: Synchronisation requires byte 0x50 immediately followed by byte 0x36. A different second byte is thrown away and the hunt resumes at the first byte, so 0x50 0x50 0x36 does not synchronise. No memory write occurs before synchronisation.
- R6: In load mode payload byte k (k = page*PAGE_BYTES + offset, counting from 0) is written at `mem_addr` = k with a one-cycle `mem_wr_en` pulse. Writes come in increasing address order, and none occur after `done`.
- R7: The byte after the last payload byte is compared with the modulo-256 sum of the payload. `done` rises after that byte in both cases. `error` rises as well when the two differ. Neither flag rises before the sum byte.
- R8: In verify mode (`verify_mode`=1) no write occurs. Each payload byte is compared with `mem_rd_data` while `mem_addr` shows its index. The first mismatch raises `error` and `done` at once, and later bytes are ignored.
- R9: Once raised, `done` and `error` keep their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tape_in | input | 1 | Comparator output from the tape, asynchronous |
| verify_mode | input | 1 | 1 = compare with memory, 0 = load into memory |
| mem_addr | output | AW | Index of the payload byte expected next |
| mem_wr_en | output | 1 | One-cycle write strobe in load mode |
| mem_wr_data | output | 8 | Byte to write |
| mem_rd_data | input | 8 | Stored byte at `mem_addr`, combinational |
| done | output | 1 | Transfer finished |
| error | output | 1 | Verify mismatch or bad sum |

## Verification
The checker assumes that `verify_mode` is held steady for a whole transfer and changes only while reset is asserted. It also assumes that `mem_rd_data` follows `mem_addr` in the same cycle. The bench changes the mode only inside its reset task, and its memory model reads without a register. Tape gaps are always kept well below TIMEOUT_CYC, except in the one byte that deliberately starts through a timeout. This means no spurious zero bits enter a frame in the middle of a transfer. Near-threshold gaps (20 and 28 cycles against a 24-cycle threshold) are used in one run to pin down the classification edge.

// File: rtl/tape_pkg.sv
package tape_pkg;
   localparam int BYTE_W = 8;

   typedef logic [BYTE_W-1:0] tape_byte_t;

   typedef enum logic [2:0] {
      ST_HUNT_A,
      ST_HUNT_B,
      ST_BODY,
      ST_SUM,
      ST_END
   } ld_state_t;
endpackage

// File: rtl/tape_edge_sync.sv
module tape_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tape_in,
   output logic edge_o
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] chain;
   logic                   last;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= tape_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else        last <= chain[TOP];
   end

   assign edge_o = chain[TOP] ^ last;
endmodule

// File: rtl/tape_bit_timer.sv
module tape_bit_timer #(
   parameter int THRESH_CYC  = 24,
   parameter int TIMEOUT_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   output logic bit_vld,
   output logic bit_val
);
   localparam int CW = $clog2(TIMEOUT_CYC + 1);

   logic [CW-1:0] cnt;
   logic          expired;

   assign expired = (cnt == CW'(TIMEOUT_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= CW'(1);
         bit_vld <= 1'b0;
         bit_val <= 1'b0;
      end else begin
         bit_vld <= 1'b0;
         if (edge_i) begin
            bit_vld <= 1'b1;
            bit_val <= (cnt < CW'(THRESH_CYC));
            cnt     <= CW'(1);
         end else if (expired) begin
            bit_vld <= 1'b1;
            bit_val <= 1'b0;
            cnt     <= CW'(1);
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tape_byte_framer.sv
module tape_byte_framer #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_vld,
   input  logic          bit_val,
   output logic          byte_vld,
   output logic [DW-1:0] byte_o
);
   localparam int BCW = $clog2(DW);

   logic           busy;
   logic [BCW-1:0] nb;
   logic [DW-1:0]  sr;
   logic [DW-1:0]  sr_next;

   assign sr_next = {bit_val, sr[DW-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         nb       <= '0;
         sr       <= '0;
         byte_vld <= 1'b0;
         byte_o   <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (!busy) begin
            if (bit_vld && !bit_val) begin
               busy <= 1'b1;
               nb   <= '0;
            end
         end else if (bit_vld) begin
            sr <= sr_next;
            nb <= nb + 1'b1;
            if (nb == BCW'(DW - 1)) begin
               busy     <= 1'b0;
               byte_vld <= 1'b1;
               byte_o   <= sr_next;
            end
         end
      end
   end
endmodule

// File: rtl/tape_loader.sv
module tape_loader
   import tape_pkg::*;
#(
   parameter int TICK_CYC     = 1000,
   parameter int THRESH_TICKS = 6,
   parameter int TIMEOUT_CYC  = 12800,
   parameter int PAGE_BYTES   = 256,
   parameter int PAGES        = 2,
   parameter int SYNC_STAGES  = 2,
   parameter logic [7:0] HDR_A = 8'h50,
   parameter logic [7:0] HDR_B = 8'h36,
   localparam int OFF_W = $clog2(PAGE_BYTES),
   localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1,
   localparam int AW    = (PAGES > 1) ? OFF_W + PG_W : OFF_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tape_in,
   input  logic          verify_mode,
   output logic [AW-1:0] mem_addr,
   output logic          mem_wr_en,
   output logic [7:0]    mem_wr_data,
   input  logic [7:0]    mem_rd_data,
   output logic          done,
   output logic          error
);
   localparam int THRESH_CYC = TICK_CYC * THRESH_TICKS;

   if (THRESH_CYC >= TIMEOUT_CYC) begin : g_bad_timeout
      $error("timeout must exceed the bit threshold");
   end
   if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
      $error("page size must be a power of two");
   end
   if (PAGES < 1) begin : g_bad_pages
      $error("at least one page is required");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are required");
   end

   logic       edge_s;
   logic       bit_vld;
   logic       bit_val;
   logic       byte_vld;
   tape_byte_t byte_q;

   tape_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tape_in(tape_in),
      .edge_o (edge_s)
   );

   tape_bit_timer #(.THRESH_CYC(THRESH_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_i (edge_s),
      .bit_vld(bit_vld),
      .bit_val(bit_val)
   );

   tape_byte_framer #(.DW(BYTE_W)) u_framer (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_vld (bit_vld),
      .bit_val (bit_val),
      .byte_vld(byte_vld),
      .byte_o  (byte_q)
   );

   ld_state_t        state;
   logic [OFF_W-1:0] off;
   logic [PG_W-1:0]  pg;
   tape_byte_t       sum;
   logic             off_wrap;
   logic             last_byte;
   logic             take;

   assign off_wrap  = (off == OFF_W'(PAGE_BYTES - 1));
   assign last_byte = off_wrap && (pg == PG_W'(PAGES - 1));
   assign take      = (state == ST_BODY) && byte_vld;

   if (PAGES > 1) begin : g_paged
      assign mem_addr = {pg, off};
   end else begin : g_flat
      assign mem_addr = off;
   end

   assign mem_wr_en   = take && !verify_mode;
   assign mem_wr_data = byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HUNT_A;
         off   <= '0;
         pg    <= '0;
         sum   <= '0;
         done  <= 1'b0;
         error <= 1'b0;
      end else begin
         case (state)
            ST_HUNT_A: begin
               if (byte_vld && byte_q == HDR_A) state <= ST_HUNT_B;
            end
            ST_HUNT_B: begin
               if (byte_vld) begin
                  if (byte_q == HDR_B) begin
                     state <= ST_BODY;
                     off   <= '0;
                     pg    <= '0;
                     sum   <= '0;
                  end else begin
                     state <= ST_HUNT_A;
                  end
               end
            end
            ST_BODY: begin
               if (byte_vld) begin
                  sum <= sum + byte_q;
                  if (verify_mode && byte_q != mem_rd_data) begin
                     error <= 1'b1;
                     done  <= 1'b1;
                     state <= ST_END;
                  end else if (last_byte) begin
                     state <= ST_SUM;
                  end else if (off_wrap) begin
                     off <= '0;
                     pg  <= pg + 1'b1;
                  end else begin
                     off <= off + 1'b1;
                  end
               end
            end
            ST_SUM: begin
               if (byte_vld) begin
                  done  <= 1'b1;
                  error <= (byte_q != sum);
                  state <= ST_END;
               end
            end
            default: begin
               state <= ST_END;
            end
         endcase
      end
   end
endmodule

// File: rtl/tape_loader_chk.sv
module tape_loader_chk (
   input logic clk,
   input logic rst_n,
   input logic verify_mode,
   input logic mem_wr_en,
   input logic done,
   input logic error,
   input logic bit_vld,
   input logic byte_vld
);
   AST_NO_WR_IN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> !verify_mode); // R8
   AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> !mem_wr_en); // R6
   AST_NO_WR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_wr_en); // R6
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done); // R9
   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error); // R9
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done); // R7
   AST_BYTE_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(bit_vld)); // R4
endmodule

bind tape_loader tape_loader_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .verify_mode(verify_mode),
   .mem_wr_en  (mem_wr_en),
   .done       (done),
   .error      (error),
   .bit_vld    (bit_vld),
   .byte_vld   (byte_vld)
);

// File: tb/sim_tape_loader.sv
`timescale 1ns/1ps
module sim_tape_loader;
   localparam int TOUT = 100;
   localparam int PGB  = 16;
   localparam int NPG  = 2;
   localparam int NB   = PGB * NPG;

   typedef struct { int addr; int data; } wr_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tape = 1'b0;
   logic       verify_mode = 1'b0;
   logic [4:0] mem_addr;
   logic       mem_wr_en;
   logic [7:0] mem_wr_data;
   logic [7:0] mem_rd_data;
   logic       done;
   logic       error;

   logic [7:0] mem [0:NB-1];
   logic [7:0] pay [0:NB-1];
   wr_item_t   exp_q [$];
   int total = 0;
   int bad = 0;
   int wr_seen = 0;
   int cyc = 0;
   int short_iv = 12;
   int long_iv = 36;
   bit fin = 0;

   always #5 clk = ~clk;

   tape_loader #(
      .TICK_CYC(4), .THRESH_TICKS(6), .TIMEOUT_CYC(TOUT),
      .PAGE_BYTES(PGB), .PAGES(NPG)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .tape_in(tape), .verify_mode(verify_mode),
      .mem_addr(mem_addr), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
      .mem_rd_data(mem_rd_data), .done(done), .error(error)
   );

   assign mem_rd_data = mem[mem_addr];
   always @(posedge clk) if (mem_wr_en) mem[mem_addr] <= mem_wr_data;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && mem_wr_en) begin
         wr_seen++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R5/R8", "unexpected write addr", int'(mem_addr), -1);
         end else begin
            wr_item_t e;
            e = exp_q.pop_front();
            check(int'(mem_addr) == e.addr, "R6", "write addr", int'(mem_addr), e.addr);
            check(int'(mem_wr_data) == e.data, "R6", "write data", int'(mem_wr_data), e.data);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000 && !fin) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input bit b);
      wait_cyc(b ? short_iv : long_iv);
      tape = ~tape;
   endtask

   task automatic send_byte(input logic [7:0] v, input int stops);
      send_bit(1'b0);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
      for (int s = 0; s < stops; s++) send_bit(1'b1);
   endtask

   // start bit delivered by the timeout instead of an edge (R3)
   task automatic send_byte_ts(input logic [7:0] v);
      wait_cyc(TOUT + (v[0] ? short_iv : long_iv));
      tape = ~tape;
      for (int i = 1; i < 8; i++) send_bit(v[i]);
      send_bit(1'b1);
      send_bit(1'b1);
   endtask

   task automatic ones(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b1);
   endtask

   task automatic do_reset(input bit vm);
      rst_n = 1'b0;
      tape = 1'b0;
      verify_mode = vm;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(2);
      check(done == 1'b0, "R1", "done after reset", int'(done), 0);
      check(error == 1'b0, "R1", "error after reset", int'(error), 0);
      check(mem_wr_en == 1'b0, "R1", "wr_en after reset", int'(mem_wr_en), 0);
   endtask

   function automatic logic [7:0] psum(input int flip_idx);
      logic [7:0] s = 8'h00;
      for (int i = 0; i < NB; i++) s = s + pay[i];
      return s;
   endfunction

   // driver side: pushes an expected write before each loaded byte
   task automatic send_payload(input bit load, input bit ts_first, input int stop_odd);
      for (int i = 0; i < NB; i++) begin
         if (load) exp_q.push_back('{addr: i, data: int'(pay[i])});
         if (i == 0 && ts_first) send_byte_ts(pay[i]);
         else if (i == NB - 1)   send_byte(pay[i], 0);
         else                    send_byte(pay[i], (i % 2 == 1) ? stop_odd : 2);
      end
   endtask

   initial begin
      for (int i = 0; i < NB; i++) pay[i] = 8'(i * 37 + 11);

      // run A: load, false header first, first payload byte via timeout
      do_reset(1'b0);
      ones(20);
      send_byte(8'h12, 2);
      send_byte(8'h50, 2);
      send_byte(8'h50, 2);
      send_byte(8'h36, 2);
      send_byte(8'h11, 2);
      wait_cyc(8);
      check(wr_seen == 0, "R5", "writes after 50 50 36", wr_seen, 0);
      ones(4);
      send_byte(8'h50, 2);
      send_byte(8'h36, 2);
      exp_q.push_back('{addr: 0, data: int'(pay[0])});
      send_byte_ts(pay[0]);
      check(wr_seen == 1, "R3", "byte started by timeout", wr_seen, 1);
      for (int i = 1; i < NB; i++) begin
         exp_q.push_back('{addr: i, data: int'(pay[i])});
         send_byte(pay[i], (i == NB - 1) ? 0 : 2);
      end
      wait_cyc(8);
      check(exp_q.size() == 0, "R6", "pending writes", exp_q.size(), 0);
      check(wr_seen == NB, "R6", "write count", wr_seen, NB);
      check(done == 1'b0, "R7", "done before sum byte", int'(done), 0);
      ones(2);
      send_byte(psum(-1), 0);
      wait_cyc(8);
      check(done == 1'b1, "R7", "done after good sum", int'(done), 1);
      check(error == 1'b0, "R7", "error after good sum", int'(error), 0);
      ones(2);

      // run B: verify, gaps close to the threshold, no stop bits on odd bytes
      do_reset(1'b1);
      wr_seen = 0;
      short_iv = 20;
      long_iv = 28;
      ones(20);
      send_byte(8'h50, 2);
      send_byte(8'h36, 2);
      send_payload(1'b0, 1'b0, 0);
      ones(2);
      send_byte(psum(-1), 0);
      wait_cyc(8);
      check(done == 1'b1, "R2", "done near-threshold verify", int'(done), 1);
      check(error == 1'b0, "R4", "error near-threshold verify", int'(error), 0);
      check(wr_seen == 0, "R8", "writes in verify", wr_seen, 0);
      ones(2);

      // run C: verify with a mismatch at byte 5
      do_reset(1'b1);
      short_iv = 12;
      long_iv = 36;
      ones(20);
      send_byte(8'h50, 2);
      send_byte(8'h36, 2);
      for (int i = 0; i < 5; i++) send_byte(pay[i], 2);
      wait_cyc(4);
      check(error == 1'b0, "R8", "error before mismatch", int'(error), 0);
      send_byte(pay[5] ^ 8'h40, 0);
      wait_cyc(8);
      check(error == 1'b1, "R8", "error at mismatch", int'(error), 1);
      check(done == 1'b1, "R8", "done at mismatch", int'(done), 1);
      ones(2);
      for (int i = 6; i < 10; i++) send_byte(pay[i], 2);
      wait_cyc(4);
      check(error == 1'b1, "R9", "error held", int'(error), 1);
      check(done == 1'b1, "R9", "done held", int'(done), 1);
      check(wr_seen == 0, "R8", "writes in verify", wr_seen, 0);

      // run D: load with a wrong sum byte
      do_reset(1'b0);
      wr_seen = 0;
      ones(20);
      send_byte(8'h50, 2);
      send_byte(8'h36, 2);
      send_payload(1'b1, 1'b0, 2);
      wait_cyc(8);
      check(done == 1'b0, "R7", "done before bad sum", int'(done), 0);
      check(wr_seen == NB, "R6", "write count", wr_seen, NB);
      ones(2);
      send_byte(psum(-1) + 8'h01, 0);
      wait_cyc(8);
      check(error == 1'b1, "R7", "error after bad sum", int'(error), 1);
      check(done == 1'b1, "R7", "done after bad sum", int'(done), 1);
      ones(2);
      wait_cyc(TOUT * 3);
      check(error == 1'b1 && done == 1'b1, "R9", "flags after idle", int'({done, error}), 3);

      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule